// File: doc/BRIEF.md
# Two-Pattern Delay Test Sequencer for Unate Networks

This block runs a list of two-pattern delay tests against one output cone of a combinational unate network. For each test a serial source supplies a target vector, most significant bit first, together with a tag that says whether the target is a minimal true vertex or a maximal false vertex. The bits go into a scan chain. Behind the chain sit output latches that drive the network. These latches are not loaded with an arbitrary first vector. Instead, per-bit set and reset force them to one of two fixed patterns: the bottom or the top of the unate order. The per-input parity mask defines both patterns. The bottom pattern equals the mask and the top pattern is its complement.

After a programmable settling time, the latches take the shifted target (launch). The network response is then sampled one clock later (capture). The captured bit is compared with the tag. Mismatches are counted, a sticky flag is raised, and the index of the first failing test is kept. A network with several outputs is covered by running one list per output cone.

The state sequence for each test is IDLE, then SHIFT, INIT, SETTLE, LAUNCH, CAPTURE and COMPARE, and after that either SHIFT for the next test or DONE. The transitions are:
- IDLE or DONE goes to SHIFT when start is seen. It goes straight to DONE if the list is empty.
- SHIFT goes to INIT after N_IN bits.
- INIT goes to SETTLE after one cycle.
- SETTLE goes to LAUNCH when its counter reaches settle_cycles.
- LAUNCH goes to CAPTURE, and CAPTURE goes to COMPARE.
- COMPARE goes to DONE after the last test, and to SHIFT otherwise.

Top module: `dly_test_seq`

## Requirements
- R1: After a synchronous low rst_n, the block rests idle: busy, done, src_shift, launch, capture, fail_flag and fail_count are all 0, and net_in is 0.
- R2: Each test asserts src_shift for exactly N_IN consecutive cycles. The first bit taken ends up on net_in[N_IN-1] after launch and the last bit on net_in[0]. src_tag is sampled in the first shift cycle (1 = true vertex, 0 = false vertex).
- R3: From the second shift cycle through the launch cycle, net_in holds the forced pattern. That pattern is parity when the tag is 1 and ~parity when the tag is 0.
- R4: INIT lasts one cycle and SETTLE lasts settle_cycles+1 cycles. launch is therefore high exactly settle_cycles+3 cycles after the last src_shift cycle.
- R5: At the clock edge that ends the launch cycle, net_in takes the shifted target. It keeps that value through the capture cycle.
- R6: capture is high in the cycle right after launch. net_out is sampled at the edge that ends that cycle.
- R7: The expected response equals the tag. Each mismatch adds one to fail_count in the cycle after capture, and matches leave fail_count unchanged.
- R8: fail_flag rises on the first mismatch and stays high. first_fail_idx holds the zero-based position in the list of that first failing test.
- R9: After num_tests tests, done is high and busy is low. A start pulse clears fail_count, fail_flag and first_fail_idx, then begins a new list.
- R10: A low rst_n in the middle of a list returns the block to idle at the next edge, with counters and flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a test list when idle or done |
| num_tests | input | IDX_W | Number of tests in the list |
| parity | input | N_IN | Inversion parity per network input (1 = negative unate) |
| settle_cycles | input | SET_W | Extra settling cycles before launch |
| src_bit | input | 1 | Serial target bit, MSB first |
| src_tag | input | 1 | Target tag: 1 true vertex, 0 false vertex |
| src_shift | output | 1 | Shift request; a bit is taken on every cycle it is high |
| net_in | output | N_IN | Output latches driving the network |
| launch | output | 1 | High in the cycle whose ending edge applies the target |
| capture | output | 1 | High in the cycle whose ending edge samples net_out |
| net_out | input | 1 | Network response |
| busy | output | 1 | A list is in progress |
| done | output | 1 | List finished |
| fail_count | output | CNT_W | Number of mismatching tests |
| fail_flag | output | 1 | Sticky mismatch flag |
| first_fail_idx | output | IDX_W | Index of the first mismatching test |

## Verification
The bench uses a non-symmetric parity mask and mixes true and false tags. A design that swapped the two fixed patterns, or built them from the target, would then show the wrong net_in before launch. Gap counting with settle_cycles set to 3 and to 0 exposes an off-by-one in the settle counter. A test whose bits differ end to end catches a reversed shift order. A list with two failures, of which the second is not the first test, shows whether the first-fail index is overwritten and whether a new start really clears the results. A reset taken in the middle of settling must leave the block idle, not resuming.

// File: rtl/dts_pkg.sv
package dts_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_INIT,
        ST_SETTLE,
        ST_LAUNCH,
        ST_CAPTURE,
        ST_COMPARE,
        ST_DONE
    } dts_state_e;
endpackage

// File: rtl/dts_scan_chain.sv
module dts_scan_chain #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            si,
    input  logic            force_en,
    input  logic [N_IN-1:0] set_vec,
    input  logic [N_IN-1:0] clr_vec,
    input  logic            load_en,
    output logic [N_IN-1:0] latch_q
);
    logic [N_IN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        chain_q <= '0;
        else if (shift_en) chain_q <= {chain_q[N_IN-2:0], si};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (force_en) latch_q <= (latch_q | set_vec) & ~clr_vec;
        else if (load_en)  latch_q <= chain_q;
    end

    AST_LOAD_TAKES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !force_en) |=> latch_q == $past(chain_q)); // R5
    AST_FORCE_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (force_en && (set_vec == ~clr_vec)) |=> latch_q == $past(set_vec)); // R3
endmodule

// File: rtl/dts_result.sv
module dts_result #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cmp_en,
    input  logic             expect_bit,
    input  logic             got_bit,
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] fail_count,
    output logic             fail_flag,
    output logic [IDX_W-1:0] first_idx
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail_count <= '0;
            fail_flag  <= 1'b0;
            first_idx  <= '0;
        end else if (cmp_en && (expect_bit != got_bit)) begin
            if (fail_count != '1) fail_count <= fail_count + 1'b1;
            fail_flag <= 1'b1;
            if (!fail_flag) first_idx <= idx;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !clear) |=> fail_flag); // R8
    AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !clear) |=> $stable(first_idx)); // R8
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !cmp_en) |=> $stable(fail_count)); // R7
endmodule

// File: rtl/dly_test_seq.sv
module dly_test_seq #(
    parameter int N_IN  = 8,
    parameter int SET_W = 8,
    parameter int IDX_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] num_tests,
    input  logic [N_IN-1:0]  parity,
    input  logic [SET_W-1:0] settle_cycles,
    input  logic             src_bit,
    input  logic             src_tag,
    output logic             src_shift,
    output logic [N_IN-1:0]  net_in,
    output logic             launch,
    output logic             capture,
    input  logic             net_out,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] fail_count,
    output logic             fail_flag,
    output logic [IDX_W-1:0] first_fail_idx
);
    import dts_pkg::*;

    localparam int SH_W = $clog2(N_IN + 1);
    localparam logic [SH_W-1:0] SH_LAST = SH_W'(N_IN - 1);

    dts_state_e       state, state_nx;
    logic [SH_W-1:0]  sh_cnt;
    logic [SET_W-1:0] st_cnt;
    logic [IDX_W-1:0] test_idx;
    logic             tag_q, cap_q, cur_tag, go;
    logic [N_IN-1:0]  pattern;

    assign go      = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign cur_tag = (state == ST_SHIFT && sh_cnt == '0) ? src_tag : tag_q;
    assign pattern = cur_tag ? parity : ~parity;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (go) state_nx = (num_tests == '0) ? ST_DONE : ST_SHIFT;
            ST_SHIFT:   if (sh_cnt == SH_LAST) state_nx = ST_INIT;
            ST_INIT:    state_nx = ST_SETTLE;
            ST_SETTLE:  if (st_cnt == settle_cycles) state_nx = ST_LAUNCH;
            ST_LAUNCH:  state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_COMPARE;
            ST_COMPARE: state_nx = (test_idx == num_tests - 1'b1) ? ST_DONE : ST_SHIFT;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh_cnt   <= '0;
            st_cnt   <= '0;
            test_idx <= '0;
            tag_q    <= 1'b0;
            cap_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (go) test_idx <= '0;
            if (state == ST_SHIFT) begin
                sh_cnt <= (sh_cnt == SH_LAST) ? '0 : sh_cnt + 1'b1;
                if (sh_cnt == '0) tag_q <= src_tag;
            end
            if (state == ST_INIT)    st_cnt <= '0;
            if (state == ST_SETTLE)  st_cnt <= st_cnt + 1'b1;
            if (state == ST_CAPTURE) cap_q <= net_out;
            if (state == ST_COMPARE && state_nx == ST_SHIFT) test_idx <= test_idx + 1'b1;
        end
    end

    always_comb begin
        src_shift = (state == ST_SHIFT);
        launch    = (state == ST_LAUNCH);
        capture   = (state == ST_CAPTURE);
        busy      = (state != ST_IDLE) && (state != ST_DONE);
        done      = (state == ST_DONE);
    end

    dts_scan_chain #(.N_IN(N_IN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (src_shift),
        .si       (src_bit),
        .force_en ((state == ST_SHIFT) || (state == ST_INIT)),
        .set_vec  (pattern),
        .clr_vec  (~pattern),
        .load_en  (launch),
        .latch_q  (net_in)
    );

    dts_result #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (go),
        .cmp_en     (state == ST_COMPARE),
        .expect_bit (tag_q),
        .got_bit    (cap_q),
        .idx        (test_idx),
        .fail_count (fail_count),
        .fail_flag  (fail_flag),
        .first_idx  (first_fail_idx)
    );

    AST_CAPTURE_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> capture); // R6
    AST_LAUNCH_FROM_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(launch) |-> $past(state) == ST_SETTLE); // R4
    AST_SHIFT_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_shift && sh_cnt == SH_LAST) |=> !src_shift); // R2
endmodule

// File: tb/sim_dly_test_seq.sv
`timescale 1ns/1ps
module sim_dly_test_seq;
    localparam int N = 8;

    typedef struct {
        logic [N-1:0] vec;
        logic         tag;
        logic         resp;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] num_tests = 8'd0, settle = 8'd0;
    logic [N-1:0] parity = '0;
    logic src_bit = 1'b0, src_tag = 1'b0, net_out = 1'b0;
    logic src_shift, launch, capture, busy, done, fail_flag;
    logic [N-1:0] net_in;
    logic [15:0] fail_count;
    logic [7:0] first_fail_idx;

    int errors = 0, checks = 0, cycles = 0;
    int bitptr = 0, gap = 0;
    logic prev_launch = 1'b0;
    item_t items[$];

    always #2 clk = ~clk;

    dly_test_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .num_tests(num_tests),
        .parity(parity), .settle_cycles(settle), .src_bit(src_bit), .src_tag(src_tag),
        .src_shift(src_shift), .net_in(net_in), .launch(launch), .capture(capture),
        .net_out(net_out), .busy(busy), .done(done), .fail_count(fail_count),
        .fail_flag(fail_flag), .first_fail_idx(first_fail_idx)
    );

    function automatic logic [N-1:0] pat(input logic tag);
        return tag ? parity : ~parity;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    // Driver side: push an expected item into the scoreboard queue
    task automatic push(input logic [N-1:0] v, input logic t, input logic r);
        item_t it;
        it.vec = v; it.tag = t; it.resp = r;
        items.push_back(it);
    endtask

    // Source and monitor: feed bits, pop items and compare at capture
    always @(negedge clk) begin
        if (!rst_n) begin
            bitptr = 0; gap = 0; prev_launch = 1'b0;
        end else begin
            if (src_shift) begin
                if (items.size() > 0) begin
                    src_bit = items[0].vec[N-1-bitptr];
                    src_tag = items[0].tag;
                    if (bitptr == 2) check("R3 shift pattern", 32'(net_in), 32'(pat(items[0].tag)));
                end
                bitptr++;
                gap = 0;
            end else begin
                if (bitptr != 0) check("R2 shift length", 32'(bitptr), N);
                bitptr = 0;
                gap++;
            end
            if (launch && items.size() > 0) begin
                check("R4 launch gap", 32'(gap), 32'(settle) + 3);
                check("R3 pattern at launch", 32'(net_in), 32'(pat(items[0].tag)));
            end
            if (capture && items.size() > 0) begin
                check("R6 capture follows launch", 32'(prev_launch), 1);
                check("R5 target applied", 32'(net_in), 32'(items[0].vec));
                net_out = items[0].resp;
                void'(items.pop_front());
            end
            prev_launch = launch;
        end
    end

    task automatic begin_list(input int n);
        @(negedge clk);
        num_tests = 8'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) return;
        end
        checks++;
        errors++;
        $display("FAIL R9: actual=not done expected=done");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 count", 32'(fail_count), 0);
        check("R1 flag", 32'(fail_flag), 0);
        check("R1 net_in", 32'(net_in), 0);
        check("R1 strobes", 32'({src_shift, launch, capture}), 0);
        rst_n = 1'b1;

        // List 1: mixed tags, two mismatches, first at index 1
        parity = 8'hA5; settle = 8'd3;
        push(8'h3C, 1'b1, 1'b1);
        push(8'hF0, 1'b0, 1'b1);
        push(8'h81, 1'b0, 1'b1);
        begin_list(3);
        check("R9 busy while running", 32'(busy), 1);
        wait_done();
        check("R9 idle at done", 32'(busy), 0);
        check("R7 fail count", 32'(fail_count), 2);
        check("R8 flag", 32'(fail_flag), 1);
        check("R8 first index", 32'(first_fail_idx), 1);

        // List 2: new start clears results, zero settle, all pass
        parity = 8'h0F; settle = 8'd0;
        push(8'h96, 1'b1, 1'b1);
        push(8'h01, 1'b0, 1'b0);
        begin_list(2);
        check("R9 cleared count", 32'(fail_count), 0);
        check("R9 cleared flag", 32'(fail_flag), 0);
        wait_done();
        check("R7 no mismatch", 32'(fail_count), 0);
        check("R8 flag low", 32'(fail_flag), 0);

        // List 3: reset taken mid-run
        parity = 8'h33; settle = 8'd20;
        push(8'h5A, 1'b1, 1'b0);
        push(8'hC3, 1'b0, 1'b0);
        begin_list(2);
        for (int i = 0; i < 200 && !fail_flag; i++) @(negedge clk);
        check("R7 mismatch counted", 32'(fail_count), 1);
        repeat (N + 4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        items.delete();
        check("R10 busy", 32'(busy), 0);
        check("R10 count", 32'(fail_count), 0);
        check("R10 flag", 32'(fail_flag), 0);
        check("R10 net_in", 32'(net_in), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule